// File: doc/BRIEF.md
# Multi-Source P/Q Parity Engine

This block folds a set of byte streams into dual RAID parity. For every byte offset the sources arrive one after another on a single byte-wide beat port. The engine keeps two running sums for that offset. The first is P, the plain XOR of all bytes. The second is Q, where each byte is first multiplied in GF(2^8) by a coefficient that belongs to its source, and the products are then XORed together. The Q multiply uses the polynomial x^8+x^4+x^3+x^2+1 (0x11D). When the last source of an offset has been taken, the engine presents the finished P and Q bytes with write strobes.

A start pulse sets up one run. It takes the source count, written as count minus one, and the offset count, also written as count minus one. It also takes one 8-bit coefficient per source and three mode flags:
- dual-parity enable, which adds Q to P;
- P suppression, which drops the P result while dual parity is on;
- zero check, in which nothing is written and two sticky flags are kept instead.

The zero-check flags report whether P or Q was ever nonzero during the run. They are read when done pulses, and a status write-back strobe marks the end of such a check run. The block has no address generation and no memory access.

Top module: `pq_parity_engine`

## Requirements
- R1: After reset the engine is idle: busy, done, stat_wb, p_wr, q_wr, p_err and q_err are all 0.
- R2: A start pulse takes effect only while busy is 0. When it takes effect, the engine captures cfg_src_sel, cfg_last_off, cfg_pq_en, cfg_p_dis, cfg_zero_chk and cfg_coef, and busy rises on the next cycle. A start pulse while busy is 1 is ignored, and so are later changes on the cfg inputs. Beats presented while idle are ignored.
- R3: During a run, each clock with beat_valid high takes one beat. Beats are taken in source order 0 to cfg_src_sel for each offset. The offset closes on the beat of source cfg_src_sel, and its strobes appear in the cycle right after that beat is taken.
- R4: p_out equals the XOR of the bytes of all selected sources at that offset.
- R5: q_out equals the XOR over the sources of gf(coef_s, byte_s). gf() is multiplication in GF(2^8) with the polynomial 0x11D. Source s takes its coefficient from cfg_coef bits [8s+7:8s].
- R6: A coefficient of 1 gives a Q contribution equal to the source byte, so with all coefficients at 1, Q equals P. A coefficient of 0 removes that source from Q.
- R7: With cfg_pq_en = 0 (plain XOR mode), only p_wr can strobe and q_wr stays 0.
- R8: With cfg_pq_en = 1 and cfg_p_dis = 1, p_wr stays 0 while q_wr still strobes for each offset.
- R9: With cfg_zero_chk = 1, neither p_wr nor q_wr strobes. p_err becomes 1 if any offset's P is nonzero, unless P is suppressed (cfg_pq_en and cfg_p_dis both 1). q_err becomes 1 if any offset's Q is nonzero while cfg_pq_en = 1. Both flags are cleared when a start takes effect and are valid when done is 1.
- R10: done pulses for one cycle, together with the final offset's strobes, and busy is 0 in that cycle. stat_wb pulses with done exactly when the run was a zero check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| cfg_src_sel | input | 4 | Source count minus one |
| cfg_pq_en | input | 1 | Enable Q alongside P |
| cfg_p_dis | input | 1 | Suppress P when Q is enabled |
| cfg_zero_chk | input | 1 | Check for zero instead of writing |
| cfg_last_off | input | 24 | Offset count minus one |
| cfg_coef | input | 128 | Per-source Q coefficients, 8 bits each |
| beat_valid | input | 1 | A source byte is present |
| beat_data | input | 8 | Source byte |
| busy | output | 1 | Run in progress |
| p_wr | output | 1 | P result strobe |
| p_out | output | 8 | P result byte |
| q_wr | output | 1 | Q result strobe |
| q_out | output | 8 | Q result byte |
| done | output | 1 | Final offset finished |
| p_err | output | 1 | Sticky P-nonzero flag |
| q_err | output | 1 | Sticky Q-nonzero flag |
| stat_wb | output | 1 | Status write-back request of a check run |

## Verification
A start pulse can land on the same clock edge as a beat that belongs to a run already in progress. The engine must take the beat and must drop the start together with the new configuration presented with it. The bench provokes this by pulsing start on the first beat of a run, with a different source count and mode on the cfg inputs. It then confirms that every offset's P and Q, and the final done and flags, match the first configuration. A second overlap is the last offset's result arriving in the same cycle as done and the sticky flags. That cycle is checked in every table vector.

// File: rtl/pqe_pkg.sv
package pqe_pkg;
   typedef struct packed {
      logic pq;     // Q generation enabled
      logic pdis;   // P result suppressed (with pq)
      logic zchk;   // zero-check run
   } pqe_mode_t;
endpackage

// File: rtl/pqe_gf_mul.sv
module pqe_gf_mul #(
   parameter int          DW   = 8,
   parameter logic [DW:0] POLY = 9'h11D
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);
   if (POLY[DW] != 1'b1) begin : g_bad_poly
      $error("pqe_gf_mul: POLY must have degree DW");
   end

   logic [DW-1:0] sh   [DW+1];
   logic [DW-1:0] part [DW+1];

   assign sh[0]   = a;
   assign part[0] = '0;

   for (genvar i = 0; i < DW; i++) begin : g_stage
      assign sh[i+1]   = {sh[i][DW-2:0], 1'b0} ^ (sh[i][DW-1] ? POLY[DW-1:0] : '0);
      assign part[i+1] = part[i] ^ (b[i] ? sh[i] : '0);
   end

   assign y = part[DW];
endmodule

// File: rtl/pqe_ctrl.sv
module pqe_ctrl
   import pqe_pkg::*;
#(
   parameter int NSRC  = 16,
   parameter int OFF_W = 24,
   parameter int DW    = 8,
   localparam int SEL_W = $clog2(NSRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [SEL_W-1:0]    cfg_src_sel,
   input  logic [OFF_W-1:0]    cfg_last_off,
   input  pqe_mode_t           cfg_mode,
   input  logic [NSRC*DW-1:0]  cfg_coef,
   input  logic                beat_valid,
   output logic                busy,
   output logic                launch,
   output logic                take,
   output logic                grp_end,
   output logic                run_end,
   output pqe_mode_t           mode,
   output logic [DW-1:0]       coef_cur
);
   logic [SEL_W-1:0]   sel_q, src_idx;
   logic [OFF_W-1:0]   last_q, off_cnt;
   logic [NSRC*DW-1:0] coef_q;

   assign launch   = start && !busy;
   assign take     = busy && beat_valid;
   assign grp_end  = (src_idx == sel_q);
   assign run_end  = grp_end && (off_cnt == last_q);
   assign coef_cur = coef_q[src_idx*DW +: DW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sel_q   <= '0;
         last_q  <= '0;
         mode    <= '0;
         coef_q  <= '0;
         src_idx <= '0;
         off_cnt <= '0;
      end else if (launch) begin
         busy    <= 1'b1;
         sel_q   <= cfg_src_sel;
         last_q  <= cfg_last_off;
         mode    <= cfg_mode;
         coef_q  <= cfg_coef;
         src_idx <= '0;
         off_cnt <= '0;
      end else if (take) begin
         if (grp_end) begin
            src_idx <= '0;
            if (run_end) busy <= 1'b0;
            else         off_cnt <= off_cnt + 1'b1;
         end else begin
            src_idx <= src_idx + 1'b1;
         end
      end
   end

   // R3
   src_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (src_idx <= sel_q));
   // R2
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(sel_q) && $stable(mode) && $stable(last_q)));
endmodule

// File: rtl/pqe_accum.sv
module pqe_accum
   import pqe_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          take,
   input  logic          grp_end,
   input  logic          run_end,
   input  pqe_mode_t     mode,
   input  logic [DW-1:0] data,
   input  logic [DW-1:0] prod,
   output logic          p_wr,
   output logic [DW-1:0] p_out,
   output logic          q_wr,
   output logic [DW-1:0] q_out,
   output logic          done,
   output logic          p_err,
   output logic          q_err,
   output logic          stat_wb
);
   logic [DW-1:0] p_acc, q_acc, p_nxt, q_nxt;
   logic          close, p_on, q_on;

   assign p_nxt = p_acc ^ data;
   assign q_nxt = q_acc ^ prod;
   assign close = take && grp_end;
   assign p_on  = !(mode.pq && mode.pdis);
   assign q_on  = mode.pq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_acc <= '0;  q_acc <= '0;
         p_out <= '0;  q_out <= '0;
         p_wr  <= 1'b0; q_wr <= 1'b0;
         done  <= 1'b0; stat_wb <= 1'b0;
         p_err <= 1'b0; q_err <= 1'b0;
      end else begin
         p_wr    <= close && !mode.zchk && p_on;
         q_wr    <= close && !mode.zchk && q_on;
         done    <= take && run_end;
         stat_wb <= take && run_end && mode.zchk;
         if (take) begin
            p_acc <= close ? '0 : p_nxt;
            q_acc <= close ? '0 : q_nxt;
         end
         if (close) begin
            p_out <= p_nxt;
            q_out <= q_nxt;
         end
         if (launch) begin
            p_err <= 1'b0;
            q_err <= 1'b0;
         end else if (close && mode.zchk) begin
            if (p_on && (p_nxt != '0)) p_err <= 1'b1;
            if (q_on && (q_nxt != '0)) q_err <= 1'b1;
         end
      end
   end

   // R9
   chk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode.zchk |-> (!p_wr && !q_wr));
   // R7
   xor_no_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_wr |-> mode.pq);
   // R8
   p_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_wr |-> !(mode.pq && mode.pdis));
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   stat_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wb |-> done);
endmodule

// File: rtl/pq_parity_engine.sv
module pq_parity_engine
   import pqe_pkg::*;
#(
   parameter int          NSRC  = 16,
   parameter int          OFF_W = 24,
   parameter int          DW    = 8,
   parameter logic [DW:0] POLY  = 9'h11D,
   localparam int SEL_W = $clog2(NSRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [SEL_W-1:0]    cfg_src_sel,
   input  logic                cfg_pq_en,
   input  logic                cfg_p_dis,
   input  logic                cfg_zero_chk,
   input  logic [OFF_W-1:0]    cfg_last_off,
   input  logic [NSRC*DW-1:0]  cfg_coef,
   input  logic                beat_valid,
   input  logic [DW-1:0]       beat_data,
   output logic                busy,
   output logic                p_wr,
   output logic [DW-1:0]       p_out,
   output logic                q_wr,
   output logic [DW-1:0]       q_out,
   output logic                done,
   output logic                p_err,
   output logic                q_err,
   output logic                stat_wb
);
   if (NSRC < 2 || (1 << SEL_W) != NSRC) begin : g_bad_nsrc
      $error("pq_parity_engine: NSRC must be a power of two, at least 2");
   end

   pqe_mode_t     cfg_mode, mode;
   logic          launch, take, grp_end, run_end;
   logic [DW-1:0] coef_cur, prod;

   assign cfg_mode = '{pq: cfg_pq_en, pdis: cfg_p_dis, zchk: cfg_zero_chk};

   pqe_ctrl #(.NSRC(NSRC), .OFF_W(OFF_W), .DW(DW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_src_sel(cfg_src_sel),
      .cfg_last_off(cfg_last_off), .cfg_mode(cfg_mode), .cfg_coef(cfg_coef),
      .beat_valid(beat_valid), .busy(busy), .launch(launch), .take(take),
      .grp_end(grp_end), .run_end(run_end), .mode(mode), .coef_cur(coef_cur));

   pqe_gf_mul #(.DW(DW), .POLY(POLY)) u_mul (
      .a(beat_data), .b(coef_cur), .y(prod));

   pqe_accum #(.DW(DW)) u_acc (
      .clk(clk), .rst_n(rst_n), .launch(launch), .take(take),
      .grp_end(grp_end), .run_end(run_end), .mode(mode), .data(beat_data),
      .prod(prod), .p_wr(p_wr), .p_out(p_out), .q_wr(q_wr), .q_out(q_out),
      .done(done), .p_err(p_err), .q_err(q_err), .stat_wb(stat_wb));

   // R10
   idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/pq_parity_engine_test.sv
module pq_parity_engine_test;
   timeunit 1ns;
   timeprecision 1ps;

   typedef struct packed {
      logic [3:0] sel;
      logic       pq;
      logic       pdis;
      logic       zchk;
      logic [7:0] last;
      logic [7:0] seed;
      logic [1:0] dmode;
      logic [1:0] cmode;
   } vec_t;

   // sel pq pdis zchk last seed dmode cmode
   localparam vec_t VTAB [9] = '{
      '{4'd15, 1'b1, 1'b0, 1'b0, 8'd3, 8'd1, 2'd0, 2'd0},  // R4 R5 all sources
      '{4'd0,  1'b0, 1'b0, 1'b0, 8'd2, 8'd9, 2'd0, 2'd0},  // R7 single source
      '{4'd4,  1'b1, 1'b1, 1'b0, 8'd2, 8'd3, 2'd0, 2'd0},  // R8
      '{4'd7,  1'b1, 1'b0, 1'b0, 8'd1, 8'd5, 2'd0, 2'd1},  // R6 coef one
      '{4'd5,  1'b1, 1'b0, 1'b0, 8'd1, 8'd7, 2'd0, 2'd2},  // R6 coef zero
      '{4'd3,  1'b1, 1'b0, 1'b1, 8'd2, 8'd2, 2'd1, 2'd1},  // R9 both zero
      '{4'd5,  1'b1, 1'b0, 1'b1, 8'd3, 8'd4, 2'd0, 2'd0},  // R9 both nonzero
      '{4'd2,  1'b0, 1'b0, 1'b1, 8'd1, 8'd6, 2'd0, 2'd0},  // R9 P only
      '{4'd3,  1'b1, 1'b1, 1'b1, 8'd1, 8'd2, 2'd1, 2'd0}   // R9 P suppressed
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [3:0]   cfg_src_sel = '0;
   logic         cfg_pq_en = 1'b0, cfg_p_dis = 1'b0, cfg_zero_chk = 1'b0;
   logic [23:0]  cfg_last_off = '0;
   logic [127:0] cfg_coef = '0;
   logic         beat_valid = 1'b0;
   logic [7:0]   beat_data = '0;
   logic         busy, p_wr, q_wr, done, p_err, q_err, stat_wb;
   logic [7:0]   p_out, q_out;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pq_parity_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_src_sel(cfg_src_sel),
      .cfg_pq_en(cfg_pq_en), .cfg_p_dis(cfg_p_dis), .cfg_zero_chk(cfg_zero_chk),
      .cfg_last_off(cfg_last_off), .cfg_coef(cfg_coef), .beat_valid(beat_valid),
      .beat_data(beat_data), .busy(busy), .p_wr(p_wr), .p_out(p_out),
      .q_wr(q_wr), .q_out(q_out), .done(done), .p_err(p_err), .q_err(q_err),
      .stat_wb(stat_wb));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !finished) begin
         errors++;
         $display("FAIL watchdog actual %0d expected <100000 cycles", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", r, act, exp);
      end
   endtask

   function automatic logic [7:0] gfref(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] pr = '0;
      for (int i = 0; i < 8; i++) if (b[i]) pr ^= 16'(a) << i;
      for (int i = 15; i >= 8; i--) if (pr[i]) pr ^= 16'h11D << (i - 8);
      return pr[7:0];
   endfunction

   function automatic logic [7:0] dat(input int s, input int o, input int seed, input int dm);
      if (dm == 1) return 8'(((s >> 1) * 29 + o * 13 + seed) & 255);
      return 8'((s * 37 + o * 11 + seed * 7 + 3) & 255);
   endfunction

   function automatic logic [7:0] cof(input int s, input int seed, input int cm);
      if (cm == 1) return 8'd1;
      if (cm == 2 && s[0]) return 8'd0;
      return 8'((s * 53 + seed + 1) & 255);
   endfunction

   task automatic run_case(input vec_t v, input bit poke);
      logic [7:0] pe, qe;
      bit perr = 0, qerr = 0;
      bit pw = !v.zchk && !(v.pq && v.pdis);
      bit qw = !v.zchk && v.pq;
      string pt = v.zchk ? "R9" : ((v.pq && v.pdis) ? "R8" : "R3");
      string qt = v.zchk ? "R9" : (!v.pq ? "R7" : "R3");
      @(negedge clk);
      cfg_src_sel = v.sel; cfg_pq_en = v.pq; cfg_p_dis = v.pdis;
      cfg_zero_chk = v.zchk; cfg_last_off = 24'(v.last);
      for (int s = 0; s < 16; s++) cfg_coef[s*8 +: 8] = cof(s, int'(v.seed), int'(v.dmode == 0 ? v.cmode : v.cmode));
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int o = 0; o <= int'(v.last); o++) begin
         pe = '0; qe = '0;
         for (int s = 0; s <= int'(v.sel); s++) begin
            @(negedge clk);
            beat_data = dat(s, o, int'(v.seed), int'(v.dmode));
            beat_valid = 1'b1;
            pe ^= beat_data;
            qe ^= gfref(cof(s, int'(v.seed), int'(v.cmode)), beat_data);
            if (poke && o == 0 && s == 0) begin
               start = 1'b1; cfg_src_sel = 4'd0; cfg_pq_en = ~v.pq;
               cfg_zero_chk = ~v.zchk; cfg_last_off = 24'd0;
            end
            @(posedge clk);
            #1;
            if (poke && o == 0 && s == 0) begin
               start = 1'b0; chk("R2 busy kept", busy, 1);
            end
            if (s == int'(v.sel)) begin
               chk({pt, " p_wr"}, p_wr, pw);
               chk({qt, " q_wr"}, q_wr, qw);
               if (pw) chk("R4 p_out", p_out, pe);
               if (qw) chk("R5 q_out", q_out, qe);
               if (pw && qw && v.cmode == 1) chk("R6 q equals p", q_out, p_out);
               if (v.zchk) begin
                  if (!(v.pq && v.pdis) && pe != 0) perr = 1;
                  if (v.pq && qe != 0) qerr = 1;
               end
               if (o == int'(v.last)) begin
                  chk("R10 done", done, 1);
                  chk("R10 stat_wb", stat_wb, v.zchk);
                  chk("R10 busy low", busy, 0);
                  chk("R9 p_err", p_err, perr);
                  chk("R9 q_err", q_err, qerr);
               end else begin
                  chk("R10 no early done", done, 0);
               end
            end
         end
      end
      @(negedge clk);
      beat_valid = 1'b0;
      @(posedge clk);
      #1;
      chk("R10 done one cycle", done, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 strobes", {30'd0, p_wr, q_wr}, 0);
      chk("R1 flags", {30'd0, p_err, q_err}, 0);
      chk("R1 stat_wb", stat_wb, 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 9; i++) run_case(VTAB[i], 1'b0);

      // R2: beats while idle must not disturb the next run
      @(negedge clk);
      beat_valid = 1'b1; beat_data = 8'hA5;
      repeat (3) @(posedge clk);
      #1;
      chk("R2 idle beats no strobe", {30'd0, p_wr, q_wr}, 0);
      chk("R2 idle beats busy", busy, 0);
      @(negedge clk);
      beat_valid = 1'b0;
      run_case(VTAB[3], 1'b0);

      // R2: start together with a beat during a run is ignored
      run_case(VTAB[0], 1'b1);
      run_case(VTAB[6], 1'b1);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule